// File: doc/BRIEF.md
# Two-Character Word Serializer with Loopback and Line Disable

This block turns a parallel word built from two 10-bit encoded characters into a serial bit stream, one bit per bit clock. A word strobe, high for one bit clock out of every twenty, marks when the next word is taken from the parallel input. A holding register takes the new word while the previous one is still being shifted out. Each word therefore starts on the output exactly one word period after it was captured, and consecutive words follow one another with no gap.

The output is a complementary pair. A line-disable input (active-low enable) parks the pair with the true side high. A wrap input does the same and also sends the serialized stream to the receive-side bit output in place of the external serial input. Encoding, clock generation and the analog drivers sit outside this block. The words it receives are assumed to be already encoded.

Top module: `word_serializer`

## Requirements
- R1: A word present on `tx_word` at a clock edge where `word_stb` is high has its bit 0 on `line_p` in the cycle that follows the clock edge 20 cycles later, which is the next strobe edge.
- R2: Bits leave least significant first. Bit i of a word is on `line_p` i cycles after bit 0, up to bit 19.
- R3: Bits 0..9 (the first character) go out before bits 10..19 (the second character), with no gap or reordering at the character boundary.
- R4: Words captured on consecutive strobes come out back to back. Bit 0 of a word follows bit 19 of the previous word directly.
- R5: After a synchronous reset, `line_p` stays 1 and `line_n` stays 0 until the first captured word reaches the shift register. This holds during the 20 cycles after the first strobe.
- R6: While `tx_en_n` is 1, `line_p` is 1 and `line_n` is 0. When `tx_en_n` returns to 0 (with `wrap_en` at 0), the stream continues at its current bit.
- R7: While `wrap_en` is 1, the pair is parked (`line_p` 1, `line_n` 0) and `rx_bit` carries the serialized bit. While `wrap_en` is 0, `rx_bit` equals `ext_rx_in`.
- R8: `line_n` is the inverse of `line_p` in every cycle.
- R9: A value on `tx_word` in a cycle where `word_stb` is 0 has no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | One-cycle word capture strobe, once per 20 cycles |
| tx_word | input | 20 | Parallel word; bits 0..9 first character, 10..19 second |
| tx_en_n | input | 1 | Active-low line enable; 1 parks the line high |
| wrap_en | input | 1 | Internal loopback select; also parks the line high |
| ext_rx_in | input | 1 | External serial input for the receive path |
| line_p | output | 1 | Serial output, true side |
| line_n | output | 1 | Serial output, complement side |
| rx_bit | output | 1 | Bit handed to the receive path (loopback or external) |

## Verification
The bench builds the block with its default parameters: two characters of ten bits each, giving a 20-bit word and a 20-cycle word period. With these values the bench can reach the boundary between bit 9 and bit 10, the full one-period gap between capture and first bit, and the seam from bit 19 of one word to bit 0 of the next. Line disable and wrap are switched in the middle of a word, and reset is applied while a stream is running. These cases show whether the shift position survives the gating and whether the line parks high again after reset.

// File: rtl/fcser_pkg.sv
package fcser_pkg;
    localparam int CHAR_W_DEF = 10;
    localparam int CHAR_N_DEF = 2;

    typedef struct packed {
        logic p;
        logic n;
    } line_pair_t;

    function automatic line_pair_t drive_pair(input logic park, input logic bit_v);
        line_pair_t r;
        r.p = park ? 1'b1 : bit_v;
        r.n = ~r.p;
        return r;
    endfunction
endpackage

// File: rtl/word_hold.sv
module word_hold #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] hold_q,
    output logic              hold_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else if (stb) begin
            hold_q   <= din;
            hold_vld <= 1'b1;
        end
    end

    // R9: holding register only moves on a strobe
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(hold_q));
    assert_hold_valid_R1: assert property (@(posedge clk) disable iff (rst)
        stb |=> hold_vld);
endmodule

// File: rtl/shift_engine.sv
module shift_engine #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [WORD_W-1:0] hold_q,
    input  logic              hold_vld,
    output logic              ser_bit,
    output logic              loaded
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            loaded <= 1'b0;
        end else if (stb) begin
            if (hold_vld) begin
                sh_q   <= hold_q;
                loaded <= 1'b1;
            end
        end else begin
            sh_q <= {1'b0, sh_q[WORD_W-1:1]};
        end
    end

    assign ser_bit = loaded ? sh_q[0] : 1'b1;

    // R2: between strobes the word moves one place toward bit 0
    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (rst)
        (!stb && loaded) |=> sh_q[WORD_W-2:0] == $past(sh_q[WORD_W-1:1]));
    // R4: a strobe hands the buffered word over without a gap
    assert_handover_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && hold_vld) |=> (loaded && sh_q == $past(hold_q)));
endmodule

// File: rtl/line_gate.sv
module line_gate
    import fcser_pkg::*;
(
    input  logic wrap_en,
    input  logic tx_en_n,
    input  logic ser_bit,
    input  logic ext_rx_in,
    output logic line_p,
    output logic line_n,
    output logic rx_bit
);
    line_pair_t pair;

    always_comb begin
        pair   = drive_pair(wrap_en | tx_en_n, ser_bit);
        rx_bit = wrap_en ? ser_bit : ext_rx_in;
    end

    assign line_p = pair.p;
    assign line_n = pair.n;
endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import fcser_pkg::*;
#(
    parameter int CHAR_W = CHAR_W_DEF,
    parameter int CHAR_N = CHAR_N_DEF,
    localparam int WORD_W = CHAR_W * CHAR_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_en_n,
    input  logic              wrap_en,
    input  logic              ext_rx_in,
    output logic              line_p,
    output logic              line_n,
    output logic              rx_bit
);
    logic [WORD_W-1:0] hold_q;
    logic              hold_vld;
    logic              ser_bit;
    logic              loaded;

    word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst(rst), .stb(word_stb), .din(tx_word),
        .hold_q(hold_q), .hold_vld(hold_vld)
    );

    shift_engine #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .stb(word_stb), .hold_q(hold_q),
        .hold_vld(hold_vld), .ser_bit(ser_bit), .loaded(loaded)
    );

    line_gate u_gate (
        .wrap_en(wrap_en), .tx_en_n(tx_en_n), .ser_bit(ser_bit),
        .ext_rx_in(ext_rx_in), .line_p(line_p), .line_n(line_n),
        .rx_bit(rx_bit)
    );

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (line_p && !line_n));
    assert_parked_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_en_n || wrap_en) |-> (line_p && !line_n));
    assert_wrap_path_R7: assert property (@(posedge clk) disable iff (rst)
        wrap_en |-> rx_bit == ser_bit);
    assert_ext_path_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap_en |-> rx_bit == ext_rx_in);
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        line_n == !line_p);
endmodule

// File: tb/word_serializer_bench.sv
module word_serializer_bench;
    localparam int W = 20;
    localparam int NV = 8;
    // stimulus word; expected output stream is the same word, LSB first
    localparam logic [W-1:0] VEC [NV] = '{
        20'h0_03FE, 20'hF_FC00, 20'h5_5555, 20'hA_AAAA,
        20'h0_0001, 20'h8_0000, 20'h3_C0F5, 20'hF_FFFF
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_stb = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic tx_en_n = 1'b0;
    logic wrap_en = 1'b0;
    logic ext_rx_in = 1'b0;
    logic line_p, line_n, rx_bit;
    int checks = 0;
    int errors = 0;
    logic [W-1:0] junk = 20'h9_3A71;

    always #10 clk = ~clk;

    word_serializer u_word_serializer (
        .clk(clk), .rst(rst), .word_stb(word_stb), .tx_word(tx_word),
        .tx_en_n(tx_en_n), .wrap_en(wrap_en), .ext_rx_in(ext_rx_in),
        .line_p(line_p), .line_n(line_n), .rx_bit(rx_bit)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic stb, input logic [W-1:0] w);
        word_stb = stb;
        tx_word  = w;
        @(posedge clk);
        #5;
        junk = {junk[W-2:0], junk[W-1] ^ junk[16]};
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        bit idle_ok;
        bit comp_ok;
        #5;
        step(1'b0, '0);
        step(1'b0, '0);
        rst = 1'b0;
        check(line_p == 1'b1 && line_n == 1'b0, "R5 reset state", {19'd0, line_p}, 20'd1);

        // table walk: slot k captures VEC[k], stream of VEC[k-1] observed
        idle_ok = 1'b1;
        comp_ok = 1'b1;
        for (int k = 0; k <= NV; k++) begin
            got = '0;
            for (int i = 0; i < W; i++) begin
                step(i == 0, (i == 0) ? ((k < NV) ? VEC[k] : '0) : junk);
                if (line_n != ~line_p) comp_ok = 1'b0;
                if (k == 0) begin
                    if (line_p !== 1'b1) idle_ok = 1'b0;
                end else begin
                    got[i] = line_p;
                    if (k == 1 && i == 0)
                        check(line_p == VEC[0][0], "R1 first bit after one word period",
                              {19'd0, line_p}, {19'd0, VEC[0][0]});
                end
            end
            if (k > 0)
                check(got == VEC[k-1], "R2 R3 R4 R9 serialized word", got, VEC[k-1]);
        end
        check(idle_ok, "R5 line high before first word", {19'd0, idle_ok}, 20'd1);
        check(comp_ok, "R8 complement pair", {19'd0, comp_ok}, 20'd1);

        // stream of zero words: the shift register now carries zeros
        for (int c = 0; c < 40; c++) begin
            tx_en_n   = (c == 5);
            wrap_en   = (c == 10);
            ext_rx_in = (c == 10 || c == 11);
            step((c % 20) == 0, '0);
            if (c == 4)
                check(line_p == 1'b0, "R6 data before disable", {19'd0, line_p}, 20'd0);
            if (c == 5)
                check(line_p == 1'b1 && line_n == 1'b0, "R6 disabled line parked",
                      {18'd0, line_p, line_n}, 20'd2);
            if (c == 6)
                check(line_p == 1'b0, "R6 stream resumes", {19'd0, line_p}, 20'd0);
            if (c == 10) begin
                check(line_p == 1'b1 && line_n == 1'b0, "R7 wrap parks line",
                      {18'd0, line_p, line_n}, 20'd2);
                check(rx_bit == 1'b0, "R7 loopback carries stream", {19'd0, rx_bit}, 20'd0);
            end
            if (c == 11) begin
                check(rx_bit == 1'b1, "R7 external input selected", {19'd0, rx_bit}, 20'd1);
                check(line_p == 1'b0, "R7 line back to data", {19'd0, line_p}, 20'd0);
            end
            if (c == 12)
                check(rx_bit == 1'b0, "R7 external input follows", {19'd0, rx_bit}, 20'd0);
        end
        tx_en_n = 1'b0;
        wrap_en = 1'b0;

        // reset in mid stream, then first word after reset
        rst = 1'b1;
        step(1'b0, '0);
        rst = 1'b0;
        check(line_p == 1'b1 && line_n == 1'b0, "R5 parked after reset",
              {18'd0, line_p, line_n}, 20'd2);
        idle_ok = 1'b1;
        for (int i = 0; i < W; i++) begin
            step(i == 0, (i == 0) ? 20'h0_0000 : junk);
            if (line_p !== 1'b1) idle_ok = 1'b0;
        end
        check(idle_ok, "R5 high until first word after reset", {19'd0, idle_ok}, 20'd1);
        step(1'b1, 20'hF_FFFF);
        check(line_p == 1'b0, "R1 word appears one period after capture",
              {19'd0, line_p}, 20'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule